// File: doc/BRIEF.md
# Active List Graduation Tracker

This block tracks in program order the instructions that are in flight in an out-of-order core. Each dispatched instruction is given a slot in a 32-entry circular list. The slot index is also the instruction's tag, and the execution units use it to report completion. Each slot keeps two values: the logical register that the instruction writes, and the physical register that was mapped to that logical register before this instruction was renamed.

Completed instructions leave the list from the oldest end, up to four per cycle. Each one that leaves returns its old physical register to the free list. An instruction that completes with an exception is held at the oldest end and never graduates. When it becomes the oldest entry, the block walks backwards from the youngest entry, up to four entries per cycle. For each entry it hands back the logical register and the old physical register, so that the rename map can be restored. The walk covers every remaining entry, including the one that raised the exception, and leaves the list empty.

Storage is split into four banks, selected by the two low bits of the tag. Any four consecutive tags therefore read from four different banks.

Top module: `active_list`

## Requirements
- R1: After reset the list is empty: `disp_ready` is 1, `disp_tag` is 0, `rb_busy` is 0, and `grad_valid` and `undo_valid` are all zero.
- R2: An accepted dispatch (`disp_valid` and `disp_ready` both high at a clock edge) receives the tag shown on `disp_tag` before that edge. `disp_tag` then increases by one, wrapping from 31 to 0.
- R3: While 32 entries are held, `disp_ready` is 0. A dispatch request in that state is ignored and leaves `disp_tag` unchanged.
- R4: A completion on `cmp_valid`/`cmp_tag` marks the entry with that tag. An entry that has not been marked never graduates.
- R5: In the cycle after the clock edge at which the oldest entry becomes both held and completed, `grad_valid` shows graduating entries. Lane 0 is the oldest entry and higher lanes are successively younger. At most four entries graduate per cycle. `grad_preg[i]` is the old physical register recorded for lane i. The entries shown leave the list at the next edge.
- R6: `grad_valid` is always a contiguous run of ones starting at lane 0. Graduation stops at the first entry that is incomplete, and younger completed entries wait behind it.
- R7: An entry completed with `cmp_exc` = 1 never graduates, but older entries still graduate ahead of it. While it is the oldest entry and no walk is running, `disp_ready` is 0 and `grad_valid` is zero, and `rb_busy` goes to 1 at the next edge.
- R8: While `rb_busy` is 1, `undo_valid` shows up to four entries. Lane 0 is the youngest remaining entry and each higher lane is the next older one. `undo_lreg[i]` and `undo_preg[i]` are the values recorded for that entry. Where two lanes name the same logical register, the higher (older) lane must win. The shown entries are removed at the next edge. `grad_valid` and `undo_valid` are never both non-zero.
- R9: When the walk has removed the excepting entry, `rb_busy` returns to 0, the list is empty, and `disp_tag` equals the excepting entry's tag. Dispatch then resumes from that tag.
- R10: Tags and graduation run across the wrap from tag 31 to tag 0 without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_lreg | input | 5 | Logical destination register of the dispatched instruction |
| disp_old_preg | input | 6 | Physical register previously mapped to that logical register |
| disp_ready | output | 1 | A dispatch request is accepted this cycle |
| disp_tag | output | 5 | Tag given to the next accepted dispatch |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | 5 | Tag of the completing instruction |
| cmp_exc | input | 1 | The completing instruction raised an exception |
| grad_valid | output | 4 | Per-lane graduation flags, lane 0 oldest |
| grad_preg | output | 4x6 | Old physical register released by each graduating lane |
| rb_busy | output | 1 | The backward walk is running |
| undo_valid | output | 4 | Per-lane undo flags, lane 0 youngest |
| undo_lreg | output | 4x5 | Logical register to restore, per lane |
| undo_preg | output | 4x6 | Physical register to write back into the map, per lane |

## Verification
The assertions assume that `cmp_tag` names only an entry that is currently held and not yet completed, and that each tag is completed at most once. The bench keeps to this: it completes only tags it has dispatched, one at a time, and never repeats a tag. The assertions also assume that reset is held from time zero. The bench asserts reset before the first edge and drives every input at the falling edge, so no input changes near a sampling edge.

// File: rtl/al_pkg.sv
package al_pkg;

    localparam int AL_DEPTH  = 32;
    localparam int AL_LANES  = 4;
    localparam int AL_LREG_W = 5;
    localparam int AL_PREG_W = 6;

    typedef struct packed {
        logic [AL_LREG_W-1:0] lreg;
        logic [AL_PREG_W-1:0] old_preg;
    } al_entry_t;

endpackage

// File: rtl/al_store.sv
module al_store
    import al_pkg::*;
#(
    parameter int DEPTH = AL_DEPTH,
    parameter int LANES = AL_LANES,
    localparam int TW   = $clog2(DEPTH),
    localparam int BW   = $clog2(LANES),
    localparam int ROWS = DEPTH / LANES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [TW-1:0]               wr_idx,
    input  al_entry_t                   wr_ent,
    input  logic                        cmp_en,
    input  logic [TW-1:0]               cmp_idx,
    input  logic                        cmp_exc,
    input  logic [LANES-1:0][TW-1:0]    rd_idx,
    output al_entry_t [LANES-1:0]       rd_ent,
    output logic [LANES-1:0]            rd_done,
    output logic [LANES-1:0]            rd_exc
);

    al_entry_t [LANES-1:0][ROWS-1:0] ent_all;
    logic      [LANES-1:0][ROWS-1:0] done_all;
    logic      [LANES-1:0][ROWS-1:0] exc_all;

    // One bank per lane: consecutive tags fall in distinct banks.
    for (genvar b = 0; b < LANES; b++) begin : g_bank
        al_entry_t [ROWS-1:0] ent_q;
        logic      [ROWS-1:0] done_q;
        logic      [ROWS-1:0] exc_q;
        logic                 hit_wr;
        logic                 hit_cmp;

        assign hit_wr  = wr_en  && (wr_idx[BW-1:0]  == BW'(b));
        assign hit_cmp = cmp_en && (cmp_idx[BW-1:0] == BW'(b));

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                ent_q[wr_idx[TW-1:BW]] <= wr_ent;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                done_q <= '0;
                exc_q  <= '0;
            end else begin
                if (hit_wr) begin
                    done_q[wr_idx[TW-1:BW]] <= 1'b0;
                    exc_q[wr_idx[TW-1:BW]]  <= 1'b0;
                end
                if (hit_cmp) begin
                    done_q[cmp_idx[TW-1:BW]] <= 1'b1;
                    exc_q[cmp_idx[TW-1:BW]]  <= cmp_exc;
                end
            end
        end

        assign ent_all[b]  = ent_q;
        assign done_all[b] = done_q;
        assign exc_all[b]  = exc_q;
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_ent[l]  = ent_all[rd_idx[l][BW-1:0]][rd_idx[l][TW-1:BW]];
            rd_done[l] = done_all[rd_idx[l][BW-1:0]][rd_idx[l][TW-1:BW]];
            rd_exc[l]  = exc_all[rd_idx[l][BW-1:0]][rd_idx[l][TW-1:BW]];
        end
    end

endmodule

// File: rtl/al_grad_sel.sv
module al_grad_sel #(
    parameter int LANES = 4,
    parameter int CNT_W = 6
) (
    input  logic              enable,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LANES-1:0]  rd_done,
    input  logic [LANES-1:0]  rd_exc,
    output logic [LANES-1:0]  grad_mask,
    output logic [CNT_W-1:0]  grad_n,
    output logic              head_exc
);

    always_comb begin
        logic alive;
        alive  = enable;
        grad_n = '0;
        for (int l = 0; l < LANES; l++) begin
            grad_mask[l] = alive && (CNT_W'(l) < cnt) && rd_done[l] && !rd_exc[l];
            alive        = grad_mask[l];
            if (grad_mask[l]) begin
                grad_n = grad_n + CNT_W'(1);
            end
        end
        head_exc = enable && (cnt != '0) && rd_done[0] && rd_exc[0];
    end

endmodule

// File: rtl/al_undo_sel.sv
module al_undo_sel #(
    parameter int LANES = 4,
    parameter int CNT_W = 6
) (
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LANES-1:0]  undo_mask,
    output logic [CNT_W-1:0]  undo_n
);

    always_comb begin
        undo_n = '0;
        for (int l = 0; l < LANES; l++) begin
            undo_mask[l] = active && (CNT_W'(l) < cnt);
            if (undo_mask[l]) begin
                undo_n = undo_n + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/active_list.sv
module active_list
    import al_pkg::*;
#(
    parameter int DEPTH = AL_DEPTH,
    parameter int LANES = AL_LANES,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            disp_valid,
    input  logic [AL_LREG_W-1:0]            disp_lreg,
    input  logic [AL_PREG_W-1:0]            disp_old_preg,
    output logic                            disp_ready,
    output logic [TW-1:0]                   disp_tag,
    input  logic                            cmp_valid,
    input  logic [TW-1:0]                   cmp_tag,
    input  logic                            cmp_exc,
    output logic [LANES-1:0]                grad_valid,
    output logic [LANES-1:0][AL_PREG_W-1:0] grad_preg,
    output logic                            rb_busy,
    output logic [LANES-1:0]                undo_valid,
    output logic [LANES-1:0][AL_LREG_W-1:0] undo_lreg,
    output logic [LANES-1:0][AL_PREG_W-1:0] undo_preg
);

    localparam int CNT_W = TW + 1;

    logic [TW-1:0]    head_q;
    logic [TW-1:0]    tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rb_q;

    logic [LANES-1:0][TW-1:0] rd_idx;
    al_entry_t [LANES-1:0]    rd_ent;
    logic [LANES-1:0]         rd_done;
    logic [LANES-1:0]         rd_exc;
    logic [LANES-1:0]         grad_mask;
    logic [LANES-1:0]         undo_mask;
    logic [CNT_W-1:0]         grad_n;
    logic [CNT_W-1:0]         undo_n;
    logic                     head_exc;
    logic                     disp_fire;
    al_entry_t                new_ent;

    // Read ports face the head when graduating and the tail when undoing.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_idx[l] = rb_q ? (tail_q - TW'(l + 1)) : (head_q + TW'(l));
        end
    end

    assign new_ent.lreg     = disp_lreg;
    assign new_ent.old_preg = disp_old_preg;

    assign disp_ready = (cnt_q != CNT_W'(DEPTH)) && !rb_q && !head_exc;
    assign disp_fire  = disp_valid && disp_ready;

    al_store #(.DEPTH(DEPTH), .LANES(LANES)) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (disp_fire),
        .wr_idx  (tail_q),
        .wr_ent  (new_ent),
        .cmp_en  (cmp_valid),
        .cmp_idx (cmp_tag),
        .cmp_exc (cmp_exc),
        .rd_idx  (rd_idx),
        .rd_ent  (rd_ent),
        .rd_done (rd_done),
        .rd_exc  (rd_exc)
    );

    al_grad_sel #(.LANES(LANES), .CNT_W(CNT_W)) i_grad_sel (
        .enable    (!rb_q),
        .cnt       (cnt_q),
        .rd_done   (rd_done),
        .rd_exc    (rd_exc),
        .grad_mask (grad_mask),
        .grad_n    (grad_n),
        .head_exc  (head_exc)
    );

    al_undo_sel #(.LANES(LANES), .CNT_W(CNT_W)) i_undo_sel (
        .active    (rb_q),
        .cnt       (cnt_q),
        .undo_mask (undo_mask),
        .undo_n    (undo_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            rb_q   <= 1'b0;
        end else if (rb_q) begin
            tail_q <= tail_q - TW'(undo_n);
            cnt_q  <= cnt_q - undo_n;
            if (undo_n == cnt_q) begin
                rb_q <= 1'b0;
            end
        end else begin
            head_q <= head_q + TW'(grad_n);
            tail_q <= tail_q + TW'(disp_fire);
            cnt_q  <= cnt_q + CNT_W'(disp_fire) - grad_n;
            if (head_exc) begin
                rb_q <= 1'b1;
            end
        end
    end

    assign disp_tag   = tail_q;
    assign rb_busy    = rb_q;
    assign grad_valid = grad_mask;
    assign undo_valid = undo_mask;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            grad_preg[l] = rd_ent[l].old_preg;
            undo_lreg[l] = rd_ent[l].lreg;
            undo_preg[l] = rd_ent[l].old_preg;
        end
    end

endmodule

// File: rtl/al_checker.sv
module al_checker #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int TW    = $clog2(DEPTH),
    localparam int CNT_W = TW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [TW-1:0]    disp_tag,
    input logic [LANES-1:0] grad_valid,
    input logic [LANES-1:0] undo_valid,
    input logic             rb_busy,
    input logic [CNT_W-1:0] cnt
);

    assert_tag_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> (disp_tag == TW'($past(disp_tag) + 1'b1)));

    assert_refused_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready && !rb_busy) |=> (disp_tag == $past(disp_tag)));

    assert_grad_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(grad_valid) <= cnt));

    assert_grad_prefix_R6: assert property (@(posedge clk) disable iff (rst)
        (((grad_valid + LANES'(1)) & grad_valid) == LANES'(0)));

    assert_walk_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rb_busy) |-> $past(!disp_ready));

    assert_lane_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !((|grad_valid) && (|undo_valid)));

    assert_undo_prefix_R8: assert property (@(posedge clk) disable iff (rst)
        (((undo_valid + LANES'(1)) & undo_valid) == LANES'(0)));

endmodule

bind active_list al_checker #(.DEPTH(DEPTH), .LANES(LANES)) i_al_checker (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .grad_valid (grad_valid),
    .undo_valid (undo_valid),
    .rb_busy    (rb_busy),
    .cnt        (cnt_q)
);

// File: tb/test_active_list.sv
module test_active_list;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             disp_valid = 1'b0;
    logic [4:0]       disp_lreg = '0;
    logic [5:0]       disp_old_preg = '0;
    logic             disp_ready;
    logic [4:0]       disp_tag;
    logic             cmp_valid = 1'b0;
    logic [4:0]       cmp_tag = '0;
    logic             cmp_exc = 1'b0;
    logic [3:0]       grad_valid;
    logic [3:0][5:0]  grad_preg;
    logic             rb_busy;
    logic [3:0]       undo_valid;
    logic [3:0][4:0]  undo_lreg;
    logic [3:0][5:0]  undo_preg;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    active_list i_active_list (
        .clk           (clk),
        .rst           (rst),
        .disp_valid    (disp_valid),
        .disp_lreg     (disp_lreg),
        .disp_old_preg (disp_old_preg),
        .disp_ready    (disp_ready),
        .disp_tag      (disp_tag),
        .cmp_valid     (cmp_valid),
        .cmp_tag       (cmp_tag),
        .cmp_exc       (cmp_exc),
        .grad_valid    (grad_valid),
        .grad_preg     (grad_preg),
        .rb_busy       (rb_busy),
        .undo_valid    (undo_valid),
        .undo_lreg     (undo_lreg),
        .undo_preg     (undo_preg)
    );

    function automatic logic [4:0] lreg_of(input int t);
        return 5'(t) ^ 5'h0A;
    endfunction

    function automatic logic [5:0] preg_of(input int t);
        return {1'b1, 5'(t)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic dispatch(input int t);
        chk("R2 tag", int'(disp_tag), t);
        disp_valid    = 1'b1;
        disp_lreg     = lreg_of(t);
        disp_old_preg = preg_of(t);
        @(negedge clk);
        disp_valid    = 1'b0;
    endtask

    task automatic complete(input int t, input logic exc);
        cmp_valid = 1'b1;
        cmp_tag   = 5'(t);
        cmp_exc   = exc;
        @(negedge clk);
        cmp_valid = 1'b0;
        cmp_exc   = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", int'(disp_ready), 1);
        chk("R1 tag", int'(disp_tag), 0);
        chk("R1 rb_busy", int'(rb_busy), 0);
        chk("R1 grad", int'(grad_valid), 0);
        chk("R1 undo", int'(undo_valid), 0);
    endtask

    task automatic t_out_of_order();
        for (int t = 0; t < 6; t++) dispatch(t);
        chk("R2 tag after six", int'(disp_tag), 6);
        chk("R4 nothing complete", int'(grad_valid), 0);
        complete(1, 1'b0);
        complete(2, 1'b0);
        chk("R6 head incomplete", int'(grad_valid), 0);
        complete(0, 1'b0);
        chk("R5 three lanes", int'(grad_valid), 4'b0111);
        for (int l = 0; l < 3; l++) chk("R5 preg", int'(grad_preg[l]), int'(preg_of(l)));
        tick();
        chk("R6 head 3 waits", int'(grad_valid), 0);
        complete(5, 1'b0);
        complete(4, 1'b0);
        chk("R6 younger wait", int'(grad_valid), 0);
        complete(3, 1'b0);
        chk("R5 second group", int'(grad_valid), 4'b0111);
        for (int l = 0; l < 3; l++) chk("R5 preg", int'(grad_preg[l]), int'(preg_of(3 + l)));
        tick();
        chk("R5 drained", int'(grad_valid), 0);
    endtask

    task automatic t_four_cap();
        for (int t = 6; t < 12; t++) dispatch(t);
        for (int t = 11; t > 6; t--) complete(t, 1'b0);
        chk("R6 head 6 waits", int'(grad_valid), 0);
        complete(6, 1'b0);
        chk("R5 four max", int'(grad_valid), 4'b1111);
        for (int l = 0; l < 4; l++) chk("R5 preg", int'(grad_preg[l]), int'(preg_of(6 + l)));
        tick();
        chk("R5 rest", int'(grad_valid), 4'b0011);
        chk("R5 preg 10", int'(grad_preg[0]), int'(preg_of(10)));
        chk("R5 preg 11", int'(grad_preg[1]), int'(preg_of(11)));
        tick();
        chk("R5 empty", int'(grad_valid), 0);
    endtask

    task automatic t_full_wrap();
        for (int k = 0; k < 32; k++) dispatch((12 + k) % 32);
        chk("R3 full ready", int'(disp_ready), 0);
        disp_valid = 1'b1;
        disp_lreg  = 5'h1F;
        disp_old_preg = 6'h00;
        @(negedge clk);
        disp_valid = 1'b0;
        chk("R3 refused tag", int'(disp_tag), 12);
        chk("R3 still full", int'(disp_ready), 0);
        for (int k = 0; k < 32; k++) begin
            int t;
            t = (12 + k) % 32;
            complete(t, 1'b0);
            chk("R10 one lane", int'(grad_valid), 4'b0001);
            chk("R10 preg", int'(grad_preg[0]), int'(preg_of(t)));
            if (k == 1) chk("R3 ready again", int'(disp_ready), 1);
        end
        tick();
        chk("R10 drained", int'(grad_valid), 0);
        chk("R10 tail", int'(disp_tag), 12);
    endtask

    task automatic t_exception();
        for (int t = 12; t < 19; t++) dispatch(t);
        complete(14, 1'b1);
        chk("R7 exc not head", int'(grad_valid), 0);
        chk("R7 ready", int'(disp_ready), 1);
        complete(12, 1'b0);
        chk("R7 older grads", int'(grad_valid), 4'b0001);
        chk("R7 preg 12", int'(grad_preg[0]), int'(preg_of(12)));
        complete(13, 1'b0);
        chk("R7 stop at exc", int'(grad_valid), 4'b0001);
        chk("R7 preg 13", int'(grad_preg[0]), int'(preg_of(13)));
        tick();
        chk("R7 exc at head grad", int'(grad_valid), 0);
        chk("R7 exc at head ready", int'(disp_ready), 0);
        chk("R7 walk not yet", int'(rb_busy), 0);
        tick();
        chk("R7 walk started", int'(rb_busy), 1);
        chk("R8 first batch", int'(undo_valid), 4'b1111);
        chk("R8 no grad", int'(grad_valid), 0);
        chk("R8 ready low", int'(disp_ready), 0);
        for (int l = 0; l < 4; l++) begin
            chk("R8 lreg", int'(undo_lreg[l]), int'(lreg_of(18 - l)));
            chk("R8 preg", int'(undo_preg[l]), int'(preg_of(18 - l)));
        end
        tick();
        chk("R8 last batch", int'(undo_valid), 4'b0001);
        chk("R8 exc lreg", int'(undo_lreg[0]), int'(lreg_of(14)));
        chk("R8 exc preg", int'(undo_preg[0]), int'(preg_of(14)));
        tick();
        chk("R9 walk done", int'(rb_busy), 0);
        chk("R9 undo idle", int'(undo_valid), 0);
        chk("R9 ready", int'(disp_ready), 1);
        chk("R9 tag", int'(disp_tag), 14);
        dispatch(14);
        complete(14, 1'b0);
        chk("R9 resumes", int'(grad_valid), 4'b0001);
        chk("R9 preg", int'(grad_preg[0]), int'(preg_of(14)));
        tick();
        chk("R9 empty", int'(grad_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_out_of_order();
        t_four_cap();
        t_full_wrap();
        t_exception();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule